// File: doc/BRIEF.md
# SPI Register and FIFO Front End

This block is the software-visible face of an SPI master. A 32-bit single-cycle register port lets a processor queue words for transmission, collect received words, and set the serial format. The block keeps two word FIFOs between the bus and the serial shift engine. A write to the data address appends to the transmit FIFO. A read of the same address removes the oldest received word. The block does no shifting itself. It drives configuration levels into the engine and hands words across a simple request/acknowledge and valid interface.

Two control registers hold the enable, loopback, chip-select choice, frame-length code, clock mode, chip-select polarities and a frame-hold option. A separate register holds the serial clock divider. The status register combines the live FIFO levels and the engine's busy state with two sticky error flags. Software clears each error flag by writing zero to its bit. Flush commands are one-shot bits in control register 0 and always read back as zero.

Top module: `spi_regfront`

## Requirements
- R1: After reset every control and divider register reads 0, all configuration outputs are 0, and status reads 0x90 (transfer done, RX empty).
- R2: A write to offset 0x0 appends the low word to the TX FIFO. While `eng_tx_req` is high and the TX FIFO holds a word, `eng_tx_ack` is high and `eng_tx_data` shows the oldest word, which leaves the FIFO at that clock edge. Words come out in write order.
- R3: A read of offset 0x0 removes the oldest RX word. Read data of any register appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R4: Each FIFO holds FIFO_DEPTH (128) words. A data write while the TX FIFO is full is dropped, and status bit 5 is 1 while the TX FIFO is full.
- R5: A data read while the RX FIFO is empty returns 0 and changes nothing.
- R6: Writing 1 to control-0 bit 2 empties the TX FIFO, and writing 1 to bit 1 empties the RX FIFO. Both bits read back as 0.
- R7: When `eng_rx_vld` arrives while the RX FIFO is full, the word is dropped and status bit 0 (overrun) becomes 1 and stays 1.
- R8: When `eng_tx_req` is high while the TX FIFO is empty and control-1 bit 23 (hold frame) is set, status bit 1 (underrun) becomes 1 and stays 1. With bit 23 clear, the same request leaves bit 1 at 0.
- R9: A status write clears each error flag whose written bit is 0 and leaves a flag whose written bit is 1 unchanged. A new error event in the same cycle wins over the clear.
- R10: Status bit 7 is 1 when the TX FIFO is empty and `eng_busy` is low. Bit 6 follows `eng_busy`. Bit 4 is 1 when the RX FIFO is empty. Bit 2 is 1 when the RX FIFO holds at least FIFO_DEPTH/2 words. All other status bits read 0.
- R11: Control 0 (0x4) keeps bit 15 enable, bit 10 loopback and bit 6 chip-select 1 choice. Control 1 (0x8) keeps bits 7:3 frame code (word length minus 2), bit 1 clock phase, bit 0 clock polarity, bit 23 hold frame, and bits 30 and 31 as the active-high flags of chip selects 0 and 1. Each register reads back these fields with the other bits 0, and each field drives its configuration output.
- R12: Offset 0x18 holds the DIV_W-bit clock divider, which reads back zero-extended and drives `cfg_clk_div`. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address, 4-byte stride |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_tx_req | input | 1 | Engine asks for the next transmit word |
| eng_tx_ack | output | 1 | A transmit word is handed over this cycle |
| eng_tx_data | output | WORD_W | Oldest transmit word |
| eng_rx_vld | input | 1 | Engine delivers a received word |
| eng_rx_data | input | WORD_W | Received word |
| eng_busy | input | 1 | Engine is shifting |
| cfg_enable | output | 1 | Controller enable |
| cfg_loopback | output | 1 | Internal loopback select |
| cfg_cs_sel | output | 1 | 1 selects chip select 1, 0 selects chip select 0 |
| cfg_frame_code | output | 5 | Word length minus 2 |
| cfg_cpha | output | 1 | Clock phase |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cs_active_high | output | 2 | Per chip select active-high flag |
| cfg_hold_frame | output | 1 | Keep frame open between words |
| cfg_clk_div | output | DIV_W | Serial clock divider |

## Verification
The hardest states to reach are the ones at the edges of the FIFOs: a full transmit FIFO receiving one more write, and a full receive FIFO receiving more words from the engine. The bench writes 130 words and pushes 130 received words, then drains both sides in full and compares every word against a scoreboard queue. This shows that the extra words were dropped without disturbing the stored ones. Underrun is reached by requesting a word from an empty transmit FIFO twice, once with hold-frame off and once with it on. Flag clearing is tested with both written polarities.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = ADDR_W - 2;

    // word index = byte offset / 4
    localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CTL0 = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CTL1 = 3'd2;
    localparam logic [IDX_W-1:0] IDX_STAT = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DIV  = 3'd6;

    // control 0 bit positions
    localparam int C0_ENABLE = 15;
    localparam int C0_LOOP   = 10;
    localparam int C0_CSSEL  = 6;
    localparam int C0_TXFL   = 2;
    localparam int C0_RXFL   = 1;

    // control 1 bit positions
    localparam int C1_CS1HI  = 31;
    localparam int C1_CS0HI  = 30;
    localparam int C1_HOLD   = 23;
    localparam int C1_CODE_L = 3;
    localparam int C1_CPHA   = 1;
    localparam int C1_CPOL   = 0;

    typedef struct packed {
        logic enable;
        logic loopback;
        logic cs_sel;
    } ctl0_t;

    typedef struct packed {
        logic       cs1_hi;
        logic       cs0_hi;
        logic       hold;
        logic [4:0] code;
        logic       cpha;
        logic       cpol;
    } ctl1_t;

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         half
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == FULL_CNT);
    assign empty   = (st_q.cnt == '0);
    assign half    = (st_q.cnt >= HALF_CNT);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = nxt(st_q.wp);
            if (pop_ok)  st_d.rp = nxt(st_q.rp);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[st_q.wp] <= din;
    end

endmodule

// File: rtl/spi_rf_flags.sv
module spi_rf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_udr,
    input  logic set_ovr,
    input  logic wr_stat,
    input  logic keep_udr,
    input  logic keep_ovr,
    output logic udr,
    output logic ovr
);
    typedef struct packed {
        logic udr;
        logic ovr;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d.udr = set_udr || (f_q.udr && !(wr_stat && !keep_udr));
        f_d.ovr = set_ovr || (f_q.ovr && !(wr_stat && !keep_ovr));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign udr = f_q.udr;
    assign ovr = f_q.ovr;

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 128,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_tx_req,
    output logic              eng_tx_ack,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_rx_vld,
    input  logic [WORD_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    output logic              cfg_enable,
    output logic              cfg_loopback,
    output logic              cfg_cs_sel,
    output logic [4:0]        cfg_frame_code,
    output logic              cfg_cpha,
    output logic              cfg_cpol,
    output logic [1:0]        cfg_cs_active_high,
    output logic              cfg_hold_frame,
    output logic [DIV_W-1:0]  cfg_clk_div
);
    typedef struct packed {
        ctl0_t             c0;
        ctl1_t             c1;
        logic [DIV_W-1:0]  div;
        logic [BUS_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    logic wr, rd;
    logic tx_full, tx_empty, tx_half;
    logic rx_full, rx_empty, rx_half;
    logic [WORD_W-1:0] tx_head, rx_head;
    logic tx_flush, rx_flush;
    logic udr_flag, ovr_flag;
    logic [BUS_W-1:0] status, rd_val;

    assign idx = bus_addr[ADDR_W-1:2];
    assign wr  = bus_en && bus_we;
    assign rd  = bus_en && !bus_we;

    assign tx_flush   = wr && (idx == IDX_CTL0) && bus_wdata[C0_TXFL];
    assign rx_flush   = wr && (idx == IDX_CTL0) && bus_wdata[C0_RXFL];
    assign eng_tx_ack = eng_tx_req && !tx_empty;

    spi_rf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (wr && (idx == IDX_DATA)),
        .din   (bus_wdata[WORD_W-1:0]),
        .pop   (eng_tx_req),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty),
        .half  (tx_half)
    );

    spi_rf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (eng_rx_vld),
        .din   (eng_rx_data),
        .pop   (rd && (idx == IDX_DATA)),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .half  (rx_half)
    );

    spi_rf_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_udr  (eng_tx_req && tx_empty && r_q.c1.hold),
        .set_ovr  (eng_rx_vld && rx_full),
        .wr_stat  (wr && (idx == IDX_STAT)),
        .keep_udr (bus_wdata[1]),
        .keep_ovr (bus_wdata[0]),
        .udr      (udr_flag),
        .ovr      (ovr_flag)
    );

    assign eng_tx_data = tx_head;

    always_comb begin
        status = '0;
        status[7] = tx_empty && !eng_busy;
        status[6] = eng_busy;
        status[5] = tx_full;
        status[4] = rx_empty;
        status[2] = rx_half;
        status[1] = udr_flag;
        status[0] = ovr_flag;
    end

    always_comb begin
        rd_val = '0;
        case (idx)
            IDX_DATA: rd_val = rx_empty ? '0 : BUS_W'(rx_head);
            IDX_CTL0: begin
                rd_val[C0_ENABLE] = r_q.c0.enable;
                rd_val[C0_LOOP]   = r_q.c0.loopback;
                rd_val[C0_CSSEL]  = r_q.c0.cs_sel;
            end
            IDX_CTL1: begin
                rd_val[C1_CS1HI]              = r_q.c1.cs1_hi;
                rd_val[C1_CS0HI]              = r_q.c1.cs0_hi;
                rd_val[C1_HOLD]               = r_q.c1.hold;
                rd_val[C1_CODE_L+4:C1_CODE_L] = r_q.c1.code;
                rd_val[C1_CPHA]               = r_q.c1.cpha;
                rd_val[C1_CPOL]               = r_q.c1.cpol;
            end
            IDX_STAT: rd_val = status;
            IDX_DIV:  rd_val = BUS_W'(r_q.div);
            default:  rd_val = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (rd) r_d.rdata = rd_val;
        if (wr) begin
            case (idx)
                IDX_CTL0: begin
                    r_d.c0.enable   = bus_wdata[C0_ENABLE];
                    r_d.c0.loopback = bus_wdata[C0_LOOP];
                    r_d.c0.cs_sel   = bus_wdata[C0_CSSEL];
                end
                IDX_CTL1: begin
                    r_d.c1.cs1_hi = bus_wdata[C1_CS1HI];
                    r_d.c1.cs0_hi = bus_wdata[C1_CS0HI];
                    r_d.c1.hold   = bus_wdata[C1_HOLD];
                    r_d.c1.code   = bus_wdata[C1_CODE_L+4:C1_CODE_L];
                    r_d.c1.cpha   = bus_wdata[C1_CPHA];
                    r_d.c1.cpol   = bus_wdata[C1_CPOL];
                end
                IDX_DIV: r_d.div = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata          = r_q.rdata;
    assign cfg_enable         = r_q.c0.enable;
    assign cfg_loopback       = r_q.c0.loopback;
    assign cfg_cs_sel         = r_q.c0.cs_sel;
    assign cfg_frame_code     = r_q.c1.code;
    assign cfg_cpha           = r_q.c1.cpha;
    assign cfg_cpol           = r_q.c1.cpol;
    assign cfg_cs_active_high = {r_q.c1.cs1_hi, r_q.c1.cs0_hi};
    assign cfg_hold_frame     = r_q.c1.hold;
    assign cfg_clk_div        = r_q.div;

endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        eng_tx_req,
    input logic        eng_tx_ack,
    input logic        eng_rx_vld,
    input logic        tx_full,
    input logic        tx_empty,
    input logic        rx_full,
    input logic        rx_empty,
    input logic        hold,
    input logic        udr,
    input logic        ovr
);
    logic data_acc, ctl0_acc, stat_acc;
    assign data_acc = bus_en && (bus_addr[4:2] == 3'd0);
    assign ctl0_acc = bus_en && (bus_addr[4:2] == 3'd1);
    assign stat_acc = bus_en && (bus_addr[4:2] == 3'd3);

    // R6
    flush_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_acc && !bus_we) |=> (bus_rdata[2:1] == 2'b00));

    // R5
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !bus_we && rx_empty) |=> (bus_rdata == 32'd0));

    // R4
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && bus_we && tx_full && !eng_tx_ack) |=> tx_full);

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_vld && rx_full) |=> ovr);

    // R8
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && tx_empty && hold) |=> udr);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(stat_acc && bus_we && !bus_wdata[0])) |=> ovr);

    // R2
    ack_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_ack |-> (eng_tx_req && !tx_empty));
endmodule

bind spi_regfront spi_regfront_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_tx_req (eng_tx_req),
    .eng_tx_ack (eng_tx_ack),
    .eng_rx_vld (eng_rx_vld),
    .tx_full    (tx_full),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .rx_empty   (rx_empty),
    .hold       (cfg_hold_frame),
    .udr        (udr_flag),
    .ovr        (ovr_flag)
);

// File: tb/tb_spi_regfront.sv
`timescale 1ns/1ps
module tb_spi_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_req = 1'b0;
    logic        eng_tx_ack;
    logic [31:0] eng_tx_data;
    logic        eng_rx_vld = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        eng_busy = 1'b0;
    logic        cfg_enable, cfg_loopback, cfg_cs_sel, cfg_cpha, cfg_cpol, cfg_hold_frame;
    logic [4:0]  cfg_frame_code;
    logic [1:0]  cfg_cs_active_high;
    logic [7:0]  cfg_clk_div;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] tx_q[$];
    logic [31:0] rx_q[$];

    always #4 clk = ~clk;

    spi_regfront dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_req(eng_tx_req), .eng_tx_ack(eng_tx_ack), .eng_tx_data(eng_tx_data),
        .eng_rx_vld(eng_rx_vld), .eng_rx_data(eng_rx_data), .eng_busy(eng_busy),
        .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback), .cfg_cs_sel(cfg_cs_sel),
        .cfg_frame_code(cfg_frame_code), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
        .cfg_cs_active_high(cfg_cs_active_high), .cfg_hold_frame(cfg_hold_frame),
        .cfg_clk_div(cfg_clk_div)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        tick(); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick(); bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        tick(); bus_en = 1; bus_we = 0; bus_addr = a;
        tick(); d = bus_rdata; bus_en = 0;
    endtask

    // driver: a write that the FIFO must accept is recorded in the scoreboard
    task automatic tx_write(input logic [31:0] v, input bit accepted);
        bus_wr(5'h00, v);
        if (accepted) tx_q.push_back(v);
    endtask

    task automatic eng_pull();
        tick(); eng_tx_req = 1; tick(); eng_tx_req = 0;
    endtask

    task automatic eng_push(input logic [31:0] v, input bit accepted);
        tick(); eng_rx_vld = 1; eng_rx_data = v; tick(); eng_rx_vld = 0;
        if (accepted) rx_q.push_back(v);
    endtask

    task automatic rx_read_expect();
        logic [31:0] d, e;
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 32'd0;
        bus_rd(5'h00, d);
        check("R3 rx order", d, e);
    endtask

    // monitor: compares each handed-over TX word against the scoreboard (R2)
    always @(negedge clk) begin
        if (rst_n && eng_tx_req) begin
            checks++;
            if (eng_tx_ack !== (tx_q.size() > 0)) begin
                errors++;
                $display("FAIL R2 ack: got %0b expected %0b", eng_tx_ack, tx_q.size() > 0);
            end else if (eng_tx_ack) begin
                logic [31:0] e;
                e = tx_q.pop_front();
                if (eng_tx_data !== e) begin
                    errors++;
                    $display("FAIL R2 tx data: got 0x%08h expected 0x%08h", eng_tx_data, e);
                end
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1 reset state
        bus_rd(5'h0C, d); check("R1 status", d, 32'h90);
        bus_rd(5'h04, d); check("R1 ctl0", d, 32'h0);
        bus_rd(5'h08, d); check("R1 ctl1", d, 32'h0);
        bus_rd(5'h18, d); check("R1 div", d, 32'h0);
        check("R1 outputs", {cfg_enable, cfg_loopback, cfg_cs_sel, cfg_frame_code,
              cfg_cpha, cfg_cpol, cfg_cs_active_high, cfg_hold_frame, cfg_clk_div}, 32'h0);

        // R11 control fields; R6 flush bits read 0
        bus_wr(5'h04, 32'hFFFF_FFFF);
        bus_rd(5'h04, d); check("R11 ctl0 readback (R6 flush bits 0)", d, 32'h0000_8440);
        check("R11 ctl0 outputs", {cfg_enable, cfg_loopback, cfg_cs_sel}, 32'h7);
        bus_wr(5'h08, 32'h4080_0073);
        bus_rd(5'h08, d); check("R11 ctl1 readback", d, 32'h4080_0073);
        check("R11 ctl1 outputs", {cfg_cs_active_high, cfg_hold_frame, cfg_frame_code, cfg_cpha, cfg_cpol},
              {2'b01, 1'b1, 5'd14, 1'b1, 1'b1});
        bus_wr(5'h08, 32'hBF7F_FF8C);
        bus_rd(5'h08, d); check("R11 ctl1 other pattern", d, 32'h8000_0088);

        // R12 divider and unmapped offsets
        bus_wr(5'h18, 32'h0000_01A5);
        bus_rd(5'h18, d); check("R12 div readback", d, 32'hA5);
        check("R12 div output", {24'd0, cfg_clk_div}, 32'hA5);
        bus_wr(5'h10, 32'hFFFF_FFFF);
        bus_rd(5'h10, d); check("R12 unmapped read", d, 32'h0);

        // R2 ordering, R10 done bit
        for (int i = 0; i < 5; i++) tx_write(32'hA000_0000 + i, 1);
        bus_rd(5'h0C, d); check("R10 done low while queued", {31'd0, d[7]}, 32'd0);
        for (int i = 0; i < 5; i++) eng_pull();
        bus_rd(5'h0C, d); check("R10 done after drain", {31'd0, d[7]}, 32'd1);

        // R4 full TX FIFO
        for (int i = 0; i < 130; i++) tx_write(32'h5500_0000 + i, i < 128);
        bus_rd(5'h0C, d); check("R4 tx full bit", {31'd0, d[5]}, 32'd1);
        for (int i = 0; i < 128; i++) eng_pull();
        check("R4 extra words dropped", tx_q.size(), 32'd0);
        bus_rd(5'h0C, d); check("R4 tx full cleared", {31'd0, d[5]}, 32'd0);

        // R8 underrun needs hold frame
        bus_wr(5'h08, 32'h0000_0000);
        eng_pull();
        bus_rd(5'h0C, d); check("R8 no underrun without hold", {31'd0, d[1]}, 32'd0);
        bus_wr(5'h08, 32'h0080_0000);
        eng_pull();
        bus_rd(5'h0C, d); check("R8 underrun set", {31'd0, d[1]}, 32'd1);
        // R9 clear polarity
        bus_wr(5'h0C, 32'h0000_00FF);
        bus_rd(5'h0C, d); check("R9 write 1 keeps flag", {31'd0, d[1]}, 32'd1);
        bus_wr(5'h0C, 32'h0000_0000);
        bus_rd(5'h0C, d); check("R9 write 0 clears flag", {31'd0, d[1]}, 32'd0);

        // R3 RX ordering, R5 empty read
        for (int i = 0; i < 3; i++) eng_push(32'hC0DE_0000 + i, 1);
        for (int i = 0; i < 3; i++) rx_read_expect();
        bus_rd(5'h00, d); check("R5 empty read", d, 32'h0);
        bus_rd(5'h0C, d); check("R5 rx still empty", {31'd0, d[4]}, 32'd1);

        // R10 half-full threshold, R7 overrun
        for (int i = 0; i < 63; i++) eng_push(32'h7700_0000 + i, 1);
        bus_rd(5'h0C, d); check("R10 half low at 63", {31'd0, d[2]}, 32'd0);
        eng_push(32'h7700_003F, 1);
        bus_rd(5'h0C, d); check("R10 half high at 64", {31'd0, d[2]}, 32'd1);
        for (int i = 64; i < 130; i++) eng_push(32'h7700_0000 + i, i < 128);
        bus_rd(5'h0C, d); check("R7 overrun set", {31'd0, d[0]}, 32'd1);
        for (int i = 0; i < 128; i++) rx_read_expect();
        bus_rd(5'h0C, d); check("R7 overrun sticky, rx empty", {30'd0, d[4], d[0]}, 32'd3);

        // R6 flushes
        for (int i = 0; i < 3; i++) tx_write(32'hF1F1_0000 + i, 0);
        bus_wr(5'h04, 32'h0000_8444);
        bus_rd(5'h0C, d); check("R6 tx flush empties", {31'd0, d[7]}, 32'd1);
        eng_push(32'h1, 0); eng_push(32'h2, 0);
        bus_wr(5'h04, 32'h0000_8442);
        bus_rd(5'h0C, d); check("R6 rx flush empties", {31'd0, d[4]}, 32'd1);
        bus_rd(5'h00, d); check("R6 read after rx flush", d, 32'h0);

        // R10 busy
        eng_busy = 1;
        bus_rd(5'h0C, d); check("R10 busy bits", {30'd0, d[7], d[6]}, 32'd1);
        eng_busy = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule